// File: doc/BRIEF.md
# BCD digit calendar counter

This block keeps the time of day and the calendar date as separate 4-bit BCD digits. Seconds, minutes, hours, day of month and month each have a units digit and a tens digit. The year has four digits, so the full year is stored and not an offset from a base year. A separate 4-bit day-of-week count is also kept. Each accepted tick on the 1 Hz tick input adds one second. The carry then runs as far up the chain as it needs to go, up to the thousands digit of the year. The length of each month is taken from the stored month and year, and the leap rule covers the whole four-digit year.

Every digit is available at the outputs at all times. Software writes one digit per cycle through a field-select and data load port. While the stop input is high the chain is frozen, so software can rewrite the digits without a carry changing them halfway through. The busy output is high in the cycle in which an accepted tick is about to update the digits, and a reader waits for busy to be low before sampling.

A two-state control machine gates the ticks. In ST_RUN, a tick with stop low and no load in the same cycle is accepted. The transition ST_RUN to ST_HALT happens at the clock edge where stop is seen high. In ST_HALT every tick is thrown away. The transition ST_HALT to ST_RUN happens at the first edge where stop is seen low. The cycle in which stop has just gone low is therefore still spent in ST_HALT, and a tick in that cycle is also thrown away.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the outputs are as follows. The time is 00:00:00, the date is day 01, month 01, year 2000, the day of week is 0 and busy is low.
- R2: Each accepted tick adds one second. The units digits count 0 to 9. The seconds tens digit and the minutes tens digit count 0 to 5. At 59 seconds the count goes to 00 and carries into the minutes, and 59 minutes carries into the hours in the same way.
- R3: Hours count 00 to 23. An accepted tick at 23:59:59 gives 00:00:00 and advances the day by one.
- R4: When the day advances, the day of month goes to 01 and the month advances if the day was the last day of its month. Otherwise the day increments in BCD. Months 4, 6, 9 and 11 have 30 days, and months 1, 3, 5, 7, 8, 10 and 12 have 31.
- R5: February has 29 days when the four-digit year is divisible by 4 and not by 100, or is divisible by 400. Otherwise it has 28 days.
- R6: When month 12 advances, the month goes to 01 and the four-digit BCD year increments. Year 9999 wraps to 0000.
- R7: The day of week increments by one on every day advance and wraps from 6 to 0.
- R8: Stop affects the count as follows.
  - No digit advances while stop is high.
  - A tick seen while stop is high is discarded, not queued.
  - A tick in the first cycle after stop falls is also discarded.
  - Busy is never high while stop is high.
- R9: Busy is high during exactly the cycles in which a tick is accepted. The digits show the advanced value from the next clock edge on.
- R10: Loads work as follows.
  - When load_en is high, load_data is written into the digit chosen by load_sel at the clock edge.
  - The codes are: 0 second units, 1 second tens, 2 minute units, 3 minute tens, 4 hour units, 5 hour tens, 6 day of week, 7 day units, 8 day tens, 9 month units, 10 month tens, 11 year units, 12 year tens, 13 year hundreds, 14 year thousands. Code 15 writes nothing.
  - A tick in a load cycle is discarded and busy stays low.
  - Digits loaded during stop are kept, and counting resumes from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse that requests a one-second advance |
| stop | input | 1 | Freezes the count while high |
| load_en | input | 1 | Writes one digit at this clock edge |
| load_sel | input | 4 | Code of the digit to write (see R10) |
| load_data | input | 4 | Value written into the selected digit |
| sec_u | output | 4 | Seconds, units digit |
| sec_t | output | 4 | Seconds, tens digit |
| min_u | output | 4 | Minutes, units digit |
| min_t | output | 4 | Minutes, tens digit |
| hr_u | output | 4 | Hours, units digit |
| hr_t | output | 4 | Hours, tens digit |
| dow | output | 4 | Day of week, 0 to 6 |
| dom_u | output | 4 | Day of month, units digit |
| dom_t | output | 4 | Day of month, tens digit |
| mon_u | output | 4 | Month, units digit |
| mon_t | output | 4 | Month, tens digit |
| yr_u | output | 4 | Year, units digit |
| yr_t | output | 4 | Year, tens digit |
| yr_h | output | 4 | Year, hundreds digit |
| yr_k | output | 4 | Year, thousands digit |
| busy | output | 1 | High in each cycle in which a tick is accepted |

## Verification
Busy is combinational: it follows tick, stop and load_en in the same cycle, so the bench drives inputs just after a falling edge and reads busy one nanosecond later. A digit update or a load shows at the outputs after the next rising edge, so the bench checks digits at the falling edge after the cycle that caused them. The stop release is checked cycle by cycle: the tick is discarded in the first cycle and busy goes high in the second. A full day of back-to-back ticks is compared second by second, and every month end of six chosen years, together with the 28 February of each, is checked after one tick.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    localparam int DIGIT_W = 4;
    localparam int SEL_W   = 4;

    // Digit select codes for the load port
    typedef enum logic [SEL_W-1:0] {
        FLD_SEC_U = 4'd0,
        FLD_SEC_T = 4'd1,
        FLD_MIN_U = 4'd2,
        FLD_MIN_T = 4'd3,
        FLD_HR_U  = 4'd4,
        FLD_HR_T  = 4'd5,
        FLD_DOW   = 4'd6,
        FLD_DOM_U = 4'd7,
        FLD_DOM_T = 4'd8,
        FLD_MON_U = 4'd9,
        FLD_MON_T = 4'd10,
        FLD_YR_U  = 4'd11,
        FLD_YR_T  = 4'd12,
        FLD_YR_H  = 4'd13,
        FLD_YR_K  = 4'd14,
        FLD_NONE  = 4'd15
    } fld_e;

    // Tick-gating control states
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } run_st_e;

endpackage

// File: rtl/bcd_time_chain.sv
module bcd_time_chain
    import bcd_cal_pkg::*;
#(
    parameter int DW = DIGIT_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          ld_en,
    input  logic [SW-1:0] ld_sel,
    input  logic [DW-1:0] ld_data,
    output logic [DW-1:0] sec_u,
    output logic [DW-1:0] sec_t,
    output logic [DW-1:0] min_u,
    output logic [DW-1:0] min_t,
    output logic [DW-1:0] hr_u,
    output logic [DW-1:0] hr_t,
    output logic          day_carry
);

    localparam logic [DW-1:0] D0 = '0;
    localparam logic [DW-1:0] D1 = DW'(1);
    localparam logic [DW-1:0] D2 = DW'(2);
    localparam logic [DW-1:0] D3 = DW'(3);
    localparam logic [DW-1:0] D5 = DW'(5);
    localparam logic [DW-1:0] D9 = DW'(9);

    logic sec_roll, min_roll, hr_roll;
    logic min_adv, hr_adv;

    always_comb begin
        sec_roll  = (sec_u == D9) && (sec_t >= D5);
        min_roll  = (min_u == D9) && (min_t >= D5);
        hr_roll   = (hr_t >= D2) && (hr_u >= D3);
        min_adv   = adv && sec_roll;
        hr_adv    = min_adv && min_roll;
        day_carry = hr_adv && hr_roll;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_u <= D0;
            sec_t <= D0;
            min_u <= D0;
            min_t <= D0;
            hr_u  <= D0;
            hr_t  <= D0;
        end else if (ld_en) begin
            case (fld_e'(ld_sel))
                FLD_SEC_U: sec_u <= ld_data;
                FLD_SEC_T: sec_t <= ld_data;
                FLD_MIN_U: min_u <= ld_data;
                FLD_MIN_T: min_t <= ld_data;
                FLD_HR_U:  hr_u  <= ld_data;
                FLD_HR_T:  hr_t  <= ld_data;
                default: ;
            endcase
        end else if (adv) begin
            // seconds
            if (sec_u == D9) begin
                sec_u <= D0;
                sec_t <= (sec_t >= D5) ? D0 : sec_t + D1;
            end else begin
                sec_u <= sec_u + D1;
            end
            // minutes
            if (min_adv) begin
                if (min_u == D9) begin
                    min_u <= D0;
                    min_t <= (min_t >= D5) ? D0 : min_t + D1;
                end else begin
                    min_u <= min_u + D1;
                end
            end
            // hours
            if (hr_adv) begin
                if (hr_roll) begin
                    hr_u <= D0;
                    hr_t <= D0;
                end else if (hr_u == D9) begin
                    hr_u <= D0;
                    hr_t <= hr_t + D1;
                end else begin
                    hr_u <= hr_u + D1;
                end
            end
        end
    end

    AST_DAY_ROLL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        day_carry |=> (hr_u == D0) && (hr_t == D0) && (min_u == D0) && (min_t == D0) && (sec_u == D0) && (sec_t == D0)); // R3

    AST_MIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && sec_roll) |=> (sec_u == D0) && (sec_t == D0)); // R2

endmodule

// File: rtl/bcd_month_len.sv
module bcd_month_len
    import bcd_cal_pkg::*;
#(
    parameter int DW = DIGIT_W
) (
    input  logic [DW-1:0] mon_u,
    input  logic [DW-1:0] mon_t,
    input  logic [DW-1:0] yr_u,
    input  logic [DW-1:0] yr_t,
    input  logic [DW-1:0] yr_h,
    input  logic [DW-1:0] yr_k,
    output logic [5:0]    last_day
);

    localparam int BW = 2 * DW;

    logic [BW-1:0] mon_bin;
    logic [BW-1:0] yy_bin;
    logic [BW-1:0] cc_bin;
    logic          leap;

    always_comb begin
        mon_bin = BW'(mon_t) * BW'(10) + BW'(mon_u);
        yy_bin  = BW'(yr_t)  * BW'(10) + BW'(yr_u);
        cc_bin  = BW'(yr_k)  * BW'(10) + BW'(yr_h);
        // year mod 4 equals low two digits mod 4, since 100 is a multiple of 4
        if (yy_bin == '0) leap = (cc_bin[1:0] == 2'b00);
        else              leap = (yy_bin[1:0] == 2'b00);
        case (mon_bin)
            BW'(2):                          last_day = leap ? 6'd29 : 6'd28;
            BW'(4), BW'(6), BW'(9), BW'(11): last_day = 6'd30;
            default:                         last_day = 6'd31;
        endcase
    end

endmodule

// File: rtl/bcd_date_chain.sv
module bcd_date_chain
    import bcd_cal_pkg::*;
#(
    parameter int DW = DIGIT_W,
    parameter int SW = SEL_W,
    parameter logic [DIGIT_W-1:0] RST_YR_K = 4'd2,
    parameter logic [DIGIT_W-1:0] RST_YR_H = 4'd0,
    parameter logic [DIGIT_W-1:0] RST_YR_T = 4'd0,
    parameter logic [DIGIT_W-1:0] RST_YR_U = 4'd0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          day_adv,
    input  logic          ld_en,
    input  logic [SW-1:0] ld_sel,
    input  logic [DW-1:0] ld_data,
    input  logic [5:0]    last_day,
    output logic [DW-1:0] dow,
    output logic [DW-1:0] dom_u,
    output logic [DW-1:0] dom_t,
    output logic [DW-1:0] mon_u,
    output logic [DW-1:0] mon_t,
    output logic [DW-1:0] yr_u,
    output logic [DW-1:0] yr_t,
    output logic [DW-1:0] yr_h,
    output logic [DW-1:0] yr_k
);

    localparam int BW = 2 * DW;
    localparam logic [DW-1:0] D0 = '0;
    localparam logic [DW-1:0] D1 = DW'(1);
    localparam logic [DW-1:0] D6 = DW'(6);
    localparam logic [DW-1:0] D9 = DW'(9);

    logic [BW-1:0] dom_bin, mon_bin;
    logic          month_end, year_end;
    logic          mon_adv, yr_adv;

    always_comb begin
        dom_bin   = BW'(dom_t) * BW'(10) + BW'(dom_u);
        mon_bin   = BW'(mon_t) * BW'(10) + BW'(mon_u);
        month_end = dom_bin >= BW'(last_day);
        year_end  = mon_bin >= BW'(12);
        mon_adv   = day_adv && month_end;
        yr_adv    = mon_adv && year_end;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dow   <= D0;
            dom_u <= D1;
            dom_t <= D0;
            mon_u <= D1;
            mon_t <= D0;
            yr_u  <= DW'(RST_YR_U);
            yr_t  <= DW'(RST_YR_T);
            yr_h  <= DW'(RST_YR_H);
            yr_k  <= DW'(RST_YR_K);
        end else if (ld_en) begin
            case (fld_e'(ld_sel))
                FLD_DOW:   dow   <= ld_data;
                FLD_DOM_U: dom_u <= ld_data;
                FLD_DOM_T: dom_t <= ld_data;
                FLD_MON_U: mon_u <= ld_data;
                FLD_MON_T: mon_t <= ld_data;
                FLD_YR_U:  yr_u  <= ld_data;
                FLD_YR_T:  yr_t  <= ld_data;
                FLD_YR_H:  yr_h  <= ld_data;
                FLD_YR_K:  yr_k  <= ld_data;
                default: ;
            endcase
        end else if (day_adv) begin
            dow <= (dow >= D6) ? D0 : dow + D1;
            // day of month
            if (month_end) begin
                dom_u <= D1;
                dom_t <= D0;
            end else if (dom_u == D9) begin
                dom_u <= D0;
                dom_t <= dom_t + D1;
            end else begin
                dom_u <= dom_u + D1;
            end
            // month
            if (mon_adv) begin
                if (year_end) begin
                    mon_u <= D1;
                    mon_t <= D0;
                end else if (mon_u == D9) begin
                    mon_u <= D0;
                    mon_t <= mon_t + D1;
                end else begin
                    mon_u <= mon_u + D1;
                end
            end
            // four-digit year, ripple of decimal carries
            if (yr_adv) begin
                if (yr_u != D9) begin
                    yr_u <= yr_u + D1;
                end else begin
                    yr_u <= D0;
                    if (yr_t != D9) begin
                        yr_t <= yr_t + D1;
                    end else begin
                        yr_t <= D0;
                        if (yr_h != D9) begin
                            yr_h <= yr_h + D1;
                        end else begin
                            yr_h <= D0;
                            yr_k <= (yr_k == D9) ? D0 : yr_k + D1;
                        end
                    end
                end
            end
        end
    end

    AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (day_adv && dow == D6) |=> (dow == D0)); // R7

    AST_DOM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        mon_adv |=> (dom_u == D1) && (dom_t == D0)); // R4

    AST_YEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        yr_adv |=> (mon_u == D1) && (mon_t == D0) && (yr_u != $past(yr_u))); // R6

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import bcd_cal_pkg::*;
#(
    parameter int DW = DIGIT_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          stop,
    input  logic          load_en,
    input  logic [SW-1:0] load_sel,
    input  logic [DW-1:0] load_data,
    output logic [DW-1:0] sec_u,
    output logic [DW-1:0] sec_t,
    output logic [DW-1:0] min_u,
    output logic [DW-1:0] min_t,
    output logic [DW-1:0] hr_u,
    output logic [DW-1:0] hr_t,
    output logic [DW-1:0] dow,
    output logic [DW-1:0] dom_u,
    output logic [DW-1:0] dom_t,
    output logic [DW-1:0] mon_u,
    output logic [DW-1:0] mon_t,
    output logic [DW-1:0] yr_u,
    output logic [DW-1:0] yr_t,
    output logic [DW-1:0] yr_h,
    output logic [DW-1:0] yr_k,
    output logic          busy
);

    run_st_e   state_q, state_d;
    logic      adv;
    logic      day_carry;
    logic [5:0] last_day;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (stop)  state_d = ST_HALT;
            ST_HALT: if (!stop) state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // outputs of the control machine
    always_comb begin
        adv = 1'b0;
        unique case (state_q)
            ST_RUN:  adv = tick && !stop && !load_en;
            ST_HALT: adv = 1'b0;
        endcase
        busy = adv;
    end

    bcd_time_chain #(.DW(DW), .SW(SW)) time_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .ld_en     (load_en),
        .ld_sel    (load_sel),
        .ld_data   (load_data),
        .sec_u     (sec_u),
        .sec_t     (sec_t),
        .min_u     (min_u),
        .min_t     (min_t),
        .hr_u      (hr_u),
        .hr_t      (hr_t),
        .day_carry (day_carry)
    );

    bcd_month_len #(.DW(DW)) len_i (
        .mon_u    (mon_u),
        .mon_t    (mon_t),
        .yr_u     (yr_u),
        .yr_t     (yr_t),
        .yr_h     (yr_h),
        .yr_k     (yr_k),
        .last_day (last_day)
    );

    bcd_date_chain #(.DW(DW), .SW(SW)) date_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .day_adv  (day_carry),
        .ld_en    (load_en),
        .ld_sel   (load_sel),
        .ld_data  (load_data),
        .last_day (last_day),
        .dow      (dow),
        .dom_u    (dom_u),
        .dom_t    (dom_t),
        .mon_u    (mon_u),
        .mon_t    (mon_t),
        .yr_u     (yr_u),
        .yr_t     (yr_t),
        .yr_h     (yr_h),
        .yr_k     (yr_k)
    );

    AST_BUSY_NOT_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !stop); // R8

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !load_en) |=> $stable(sec_u) && $stable(min_u) && $stable(hr_u) && $stable(dom_u) && $stable(yr_u)); // R8

    AST_BUSY_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (sec_u != $past(sec_u))); // R9

    AST_LOAD_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> !busy); // R10

endmodule

// File: tb/bcd_calendar_tb_top.sv
`timescale 1ns/1ps
module bcd_calendar_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       stop = 1'b0;
    logic       load_en = 1'b0;
    logic [3:0] load_sel = 4'd0;
    logic [3:0] load_data = 4'd0;
    logic [3:0] sec_u, sec_t, min_u, min_t, hr_u, hr_t, dow;
    logic [3:0] dom_u, dom_t, mon_u, mon_t, yr_u, yr_t, yr_h, yr_k;
    logic       busy;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bcd_calendar dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .stop(stop),
        .load_en(load_en), .load_sel(load_sel), .load_data(load_data),
        .sec_u(sec_u), .sec_t(sec_t), .min_u(min_u), .min_t(min_t),
        .hr_u(hr_u), .hr_t(hr_t), .dow(dow),
        .dom_u(dom_u), .dom_t(dom_t), .mon_u(mon_u), .mon_t(mon_t),
        .yr_u(yr_u), .yr_t(yr_t), .yr_h(yr_h), .yr_k(yr_k),
        .busy(busy)
    );

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cur_time();
        return (int'(hr_t) * 10 + int'(hr_u)) * 3600 + (int'(min_t) * 10 + int'(min_u)) * 60
               + int'(sec_t) * 10 + int'(sec_u);
    endfunction

    function automatic int cur_date();
        int y;
        y = int'(yr_k) * 1000 + int'(yr_h) * 100 + int'(yr_t) * 10 + int'(yr_u);
        return y * 10000 + (int'(mon_t) * 10 + int'(mon_u)) * 100 + int'(dom_t) * 10 + int'(dom_u);
    endfunction

    function automatic bit is_leap(int y);
        return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
    endfunction

    function automatic int mlen(int y, int m);
        if (m == 2) return is_leap(y) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    // called just after a falling edge; returns just after the next one
    task automatic ld(int sel, int val);
        load_en   = 1'b1;
        load_sel  = 4'(sel);
        load_data = 4'(val);
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic set_cal(int y, int mo, int d, int h, int mi, int s, int w);
        ld(0, s % 10);  ld(1, s / 10);
        ld(2, mi % 10); ld(3, mi / 10);
        ld(4, h % 10);  ld(5, h / 10);
        ld(6, w);
        ld(7, d % 10);  ld(8, d / 10);
        ld(9, mo % 10); ld(10, mo / 10);
        ld(11, y % 10); ld(12, (y / 10) % 10);
        ld(13, (y / 100) % 10); ld(14, y / 1000);
    endtask

    task automatic tick1(output bit b);
        tick = 1'b1;
        #1 b = busy;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int years[6] = '{1900, 2000, 2023, 2024, 2100, 2400};
        bit b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 time", cur_time(), 0);
        chk("R1 date", cur_date(), 20000101);
        chk("R1 dow", int'(dow), 0);
        chk("R1 busy", int'(busy), 0);

        // R2 / R3 / R9: one full day of back-to-back ticks
        tick = 1'b1;
        for (int k = 1; k <= 86400; k++) begin
            @(negedge clk);
            chk("R2 seconds count", cur_time(), k % 86400);
        end
        chk("R9 busy while ticking", int'(busy), 1);
        tick = 1'b0;
        #1 chk("R9 busy idle", int'(busy), 0);
        chk("R3 day after midnight", cur_date(), 20000102);
        chk("R7 dow after day", int'(dow), 1);

        // R4 / R5 / R6 / R7: month ends of several years
        foreach (years[i]) begin
            for (int m = 1; m <= 12; m++) begin
                int y = years[i];
                int exp_d;
                set_cal(y, m, mlen(y, m), 23, 59, 59, 6);
                tick1(b);
                chk("R9 busy on tick", int'(b), 1);
                exp_d = (m == 12) ? (y + 1) * 10000 + 101 : y * 10000 + (m + 1) * 100 + 1;
                if (m == 12)     chk("R6 year step", cur_date(), exp_d);
                else if (m == 2) chk("R5 feb end", cur_date(), exp_d);
                else             chk("R4 month end", cur_date(), exp_d);
                chk("R3 midnight", cur_time(), 0);
                chk("R7 dow wrap", int'(dow), 0);
            end
            set_cal(years[i], 2, 28, 23, 59, 59, 3);
            tick1(b);
            chk("R5 feb 28", cur_date(),
                is_leap(years[i]) ? years[i] * 10000 + 229 : years[i] * 10000 + 301);
        end

        // R4 mid-month BCD day increment across a tens digit
        set_cal(2023, 7, 19, 23, 59, 59, 2);
        tick1(b);
        chk("R4 day 19 to 20", cur_date(), 20230720);

        // R6 year 9999 wraps to 0000
        set_cal(9999, 12, 31, 23, 59, 59, 5);
        tick1(b);
        chk("R6 year wrap", cur_date(), 101);

        // R8 stop freezes, ticks discarded; R10 load during stop
        set_cal(2024, 5, 10, 12, 34, 56, 2);
        stop = 1'b1;
        tick = 1'b1;
        for (int c = 0; c < 5; c++) begin
            #1 chk("R8 busy while stopped", int'(busy), 0);
            @(negedge clk);
        end
        chk("R8 time frozen", cur_time(), 12 * 3600 + 34 * 60 + 56);
        ld(0, 3);
        chk("R10 load during stop", cur_time(), 12 * 3600 + 34 * 60 + 53);
        stop = 1'b0;
        #1 chk("R8 resume cycle busy", int'(busy), 0);
        @(negedge clk);
        chk("R8 resume tick dropped", cur_time(), 12 * 3600 + 34 * 60 + 53);
        chk("R9 busy after resume", int'(busy), 1);
        @(negedge clk);
        tick = 1'b0;
        chk("R10 counts from loaded value", cur_time(), 12 * 3600 + 34 * 60 + 54);

        // R10 load in a tick cycle discards the tick
        tick      = 1'b1;
        load_en   = 1'b1;
        load_sel  = 4'd2;
        load_data = 4'd7;
        #1 chk("R10 busy on load", int'(busy), 0);
        @(negedge clk);
        load_en = 1'b0;
        tick    = 1'b0;
        chk("R10 only loaded digit", cur_time(), 12 * 3600 + 37 * 60 + 54);
        chk("R10 date unchanged", cur_date(), 20240510);

        // R10 select code 15 writes nothing
        ld(15, 9);
        chk("R10 code 15 time", cur_time(), 12 * 3600 + 37 * 60 + 54);
        chk("R10 code 15 date", cur_date(), 20240510);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule